// File: doc/BRIEF.md
# Six-State Single-Bit-Step Counter

This block is a free-running three-bit synchronous counter. On every rising clock edge it moves one step around a six-state cycle, and exactly one bit of the count changes on each step. All three state bits share the same clock. The count is presented directly as the state output.

A Moore output, `at_last`, marks the final state of the cycle, which is the state just before the count wraps back to all zeros. Because the output is decoded from the state alone, it is stable for the whole clock period.

The two codes outside the cycle lead only to each other, so the counter does not start up by itself. A status output, `odd_code`, is high whenever the state holds one of these codes. The reset value is a parameter with a default of zero. A non-default value lets an instance start inside the unused pair, which makes the lock-up behaviour visible at the ports.

Top module: `gray_mod6_counter`

## Requirements
- R1: Once reset is released, each rising clock edge advances the state (bits written high to low) along the cycle 000, 001, 011, 111, 110, 100 and then back to 000.
- R2: While the state is in the valid cycle, each clocked step changes exactly one of the three state bits.
- R3: `at_last` is 1 exactly when the state is 100, and 0 in every other state. It depends only on the state.
- R4: The unused codes 010 and 101 step to each other on every clock and never lead into the valid cycle.
- R5: While `rst_n` is low, the state is forced to the parameter `RST_CODE` (default 000) at once, without waiting for a clock edge.
- R6: `odd_code` is 1 exactly when the state is 010 or 101.
- R7: `at_last` is never 1 while the state holds an unused code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low, loads `RST_CODE` |
| count | output | 3 | Current state, bit 2 is the most significant |
| at_last | output | 1 | High in state 100, the last state before the wrap |
| odd_code | output | 1 | High when the state is an unused code |

## Verification
The clocked properties assume that `rst_n` is released synchronously with respect to the clock and is held stable around each rising edge. They are disabled while reset is low, so only the reset value loaded into the counter sets their starting point. The stimulus asserts reset between clock edges and releases it only while the clock is low. A second instance, reset into code 010, drives the unused-code properties with the same clock and reset.

// File: rtl/gray_mod6_counter.sv
module gray_mod6_counter #(
  parameter logic [2:0] RST_CODE = 3'b000
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [2:0] count,
  output logic       at_last,
  output logic       odd_code
);

  logic [2:0] q;
  logic [2:0] q_nxt;

  // each bit follows the bit below it; the lowest takes the inverted top bit
  assign q_nxt = {q[1], q[0], ~q[2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_CODE;
    else        q <= q_nxt;
  end

  assign count    = q;
  assign at_last  = (q == 3'b100);
  assign odd_code = (q == 3'b010) || (q == 3'b101);

endmodule

// File: rtl/gray_mod6_counter_chk.sv
module gray_mod6_counter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] count,
  input logic       at_last,
  input logic       odd_code
);

  p_single_bit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !odd_code |=> $countones(count ^ $past(count)) == 1);

  p_valid_stays_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !odd_code |=> !odd_code);

  p_last_then_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    at_last |=> count == 3'b000);

  p_zero_follows_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (count == 3'b000) |-> $past(at_last) || $past(!rst_n));

  p_no_escape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    odd_code |=> odd_code && (count != $past(count)));

  p_no_last_when_odd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    odd_code |-> !at_last);

  p_odd_flag_codes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    odd_code |-> (count[2] == count[0]) && (count[1] != count[0]));

endmodule

bind gray_mod6_counter gray_mod6_counter_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .count    (count),
  .at_last  (at_last),
  .odd_code (odd_code)
);

// File: tb/tb_gray_mod6_counter.sv
module tb_gray_mod6_counter;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [2:0] count, count_b;
  logic       at_last, at_last_b;
  logic       odd_code, odd_code_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gray_mod6_counter dut (
    .clk(clk), .rst_n(rst_n), .count(count), .at_last(at_last), .odd_code(odd_code));

  gray_mod6_counter #(.RST_CODE(3'b010)) dut_odd (
    .clk(clk), .rst_n(rst_n), .count(count_b), .at_last(at_last_b), .odd_code(odd_code_b));

  logic [2:0] ring[$] = '{3'b000, 3'b001, 3'b011, 3'b111, 3'b110, 3'b100};
  int         pos = 0;
  logic [2:0] odd_exp = 3'b010;
  logic [2:0] prev_a;

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R1 state", count, ring[pos]);
    check("R3 at_last", {2'b00, at_last}, {2'b00, pos == 5});
    check("R6 odd_code valid", {2'b00, odd_code}, 3'b000);
    check("R4 unused loop", count_b, odd_exp);
    check("R6 odd_code unused", {2'b00, odd_code_b}, 3'b001);
    check("R7 at_last unused", {2'b00, at_last_b}, 3'b000);
  endtask

  task automatic run(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      prev_a = count;
      @(posedge clk);
      pos = (pos + 1) % 6;
      odd_exp = ~odd_exp;
      @(negedge clk);
      check("R2 one bit changed", {1'b0, 2'($countones(count ^ prev_a))}, 3'b001);
      compare_all();
    end
  endtask

  initial begin
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #1;
    check("R5 reset default", count, 3'b000);
    check("R5 reset param", count_b, 3'b010);
    @(negedge clk);
    rst_n = 1'b1;
    compare_all();
    run(20);
    // asynchronous reset mid-cycle, between edges
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #1;
    check("R5 async reset", count, 3'b000);
    check("R5 async reset param", count_b, 3'b010);
    pos = 0;
    odd_exp = 3'b010;
    @(posedge clk);
    @(negedge clk);
    check("R5 held through edge", count, 3'b000);
    rst_n = 1'b1;
    run(15);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule